// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the element addresses for one DMA channel. A transfer is a grid of rows: each row holds a number of elements spaced by a signed inner stride. After the last element of a row, the address moves by a separate signed outer stride and the next row begins. The strides are independent of each other. A small outer stride combined with a large inner stride therefore walks interleaved data in de-interleaved order. A 1-D transfer is a single row.

The channel is armed by a start pulse, and a 2-bit mode picks how it runs. It can make one pass from its register inputs and stop. It can repeat that pass without end. It can follow a linked chain of descriptors read over a simple word read port. It can also walk a packed array of short descriptors whose upper address bits come from a page register. The data path that owns the channel raises one transfer strobe per element moved. The block answers each strobe at once with row-end, buffer-end and interrupt flags, and moves to the next address on the clock edge.

Top module: `dma2d_agen`

## Requirements
- R1: While reset is held and in the cycle after it ends, addr_valid, rd_req, row_done, buf_done and irq are all low.
- R2: start is taken only when the channel is idle. reg_mode selects 0 = single pass and stop, 1 = circular repeat, 2 = linked descriptor chain, 3 = descriptor array. A start pulse while a pass or a fetch is in progress has no effect.
- R3: The first address is the start address. An accepted strobe (xfer with addr_valid) that is not at a row end adds the sign-extended inner stride, shifted left by ELEM_SHIFT (default 0), to the address. At a row end it adds the outer stride the same way.
- R4: row_done is high in the cycle of the accepted strobe that consumes the last element of a row. buf_done is high with the strobe that consumes the last element of the last row. Both are combinational with xfer.
- R5: If config bit 1 is set, irq follows row_done. Otherwise irq follows buf_done.
- R6: An inner or outer count of 0 means 65536 elements or rows.
- R7: In mode 0, addr_valid drops in the cycle after buf_done and stays low.
- R8: In mode 1, the address and both counts reload after buf_done and the pass repeats with addr_valid staying high.
- R9: In mode 2, the channel reads seven words from ptr, ptr+1, ..., ptr+6, in this order: next pointer, start address, config, inner count, inner stride, outer count, outer stride. Counts and strides sit in the low bits of their words. After the buffer ends, the next descriptor is fetched from the next pointer if config bit 2 is set. Otherwise the channel goes idle.
- R10: In mode 3, each descriptor is six words (start, config, inner count, inner stride, outer count, outer stride) at ptr..ptr+5. The next descriptor follows at ptr+6. The start address keeps its low PAGE_LO_W (16) bits and takes its upper bits from reg_page.
- R11: xfer while addr_valid is low has no effect on the address sequence or the flags.
- R12: Config bit 0 selects 2-D. When it is clear, the outer count and stride are ignored and the buffer is one row.
- R13: Read port: rd_req is a one-cycle pulse with rd_addr. The reply is rd_valid with rd_data in any later cycle. No new request is made before the reply, and addr_valid is low while a fetch is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm the channel (idle only) |
| reg_mode | input | 2 | Run mode |
| reg_cfg | input | 3 | Config: bit0 2-D, bit1 per-row irq, bit2 chain |
| reg_addr | input | 32 | Start address (register modes) |
| reg_icnt | input | 16 | Elements per row |
| reg_istride | input | 16 | Signed inner stride |
| reg_ocnt | input | 16 | Rows per buffer |
| reg_ostride | input | 16 | Signed outer stride |
| reg_desc_ptr | input | 32 | First descriptor word address |
| reg_page | input | 32 | Upper address bits for array mode |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_valid | input | 1 | Read reply valid |
| rd_data | input | 32 | Read reply data |
| xfer | input | 1 | Element moved strobe |
| addr_valid | output | 1 | addr holds a live element address |
| addr | output | 32 | Current element address |
| row_done | output | 1 | Strobe consumed a row's last element |
| buf_done | output | 1 | Strobe consumed the buffer's last element |
| irq | output | 1 | Interrupt event |

## Verification
The bench derives every expected address from one closed form: start plus the row index times (inner span plus outer stride) plus the column index times the inner stride. It applies this form to 1-D runs, 2-D runs with a negative outer stride that de-interleaves, and all-negative strides. These patterns separate a wrong row-end step, a missing sign extension and a wrong count reload. Circular passes show whether the reload happens, and the per-row and per-buffer irq settings separate the two interrupt sources. Chained and array descriptors in a word memory test field order, chaining, the page merge and the next-pointer rule. A zero inner count driven through all 65536 strobes tests the wrap of the count.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned CNT_W  = 16;
  parameter int unsigned STR_W  = 16;

  typedef enum logic [1:0] {MODE_STOP, MODE_CIRC, MODE_LIST, MODE_ARRAY} agen_mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] next;
    logic [ADDR_W-1:0] start;
    logic              two_d;
    logic              irq_row;
    logic              chain;
    logic [CNT_W-1:0]  icnt;
    logic [STR_W-1:0]  istride;
    logic [CNT_W-1:0]  ocnt;
    logic [STR_W-1:0]  ostride;
  } agen_desc_t;

  // count field to element count: zero stands for 2**CNT_W
  function automatic logic [CNT_W:0] count_load(input logic [CNT_W-1:0] c);
    return (c == '0) ? ((CNT_W+1)'(1) << CNT_W) : {1'b0, c};
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [STR_W-1:0] s,
                                                  input int unsigned sh);
    logic signed [ADDR_W-1:0] ext;
    ext = ADDR_W'(signed'(s));
    return a + ADDR_W'(ext <<< sh);
  endfunction

  function automatic logic [ADDR_W-1:0] page_merge(input logic [ADDR_W-1:0] page,
                                                   input logic [ADDR_W-1:0] low,
                                                   input int unsigned lo_w);
    logic [ADDR_W-1:0] m;
    m = (ADDR_W'(1) << lo_w) - ADDR_W'(1);
    return (page & ~m) | (low & m);
  endfunction
endpackage

// File: rtl/dma2d_fetch.sv
module dma2d_fetch
  import dma2d_pkg::*;
#(
  parameter int unsigned PAGE_LO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              array_mode,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] page,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_data,
  output logic              done,
  output agen_desc_t        desc
);
  localparam logic [2:0] LAST_IDX    = 3'd6;
  localparam int unsigned ARRAY_WORDS = 6;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_e;
  fst_e              st;
  logic [2:0]        idx;
  logic [2:0]        off;
  logic [ADDR_W-1:0] base;
  logic              arr;

  assign rd_req  = (st == F_REQ);
  assign rd_addr = base + ADDR_W'(off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= F_IDLE; idx <= '0; off <= '0; base <= '0; arr <= 1'b0;
      done <= 1'b0; desc <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          base <= ptr;
          arr  <= array_mode;
          idx  <= array_mode ? 3'd1 : 3'd0;
          off  <= '0;
          st   <= F_REQ;
          if (array_mode) desc.next <= ptr + ADDR_W'(ARRAY_WORDS);
        end
        F_REQ: st <= F_WAIT;
        F_WAIT: if (rd_valid) begin
          case (idx)
            3'd0: desc.next    <= rd_data;
            3'd1: desc.start   <= arr ? page_merge(page, rd_data, PAGE_LO_W) : rd_data;
            3'd2: {desc.chain, desc.irq_row, desc.two_d} <= rd_data[2:0];
            3'd3: desc.icnt    <= rd_data[CNT_W-1:0];
            3'd4: desc.istride <= rd_data[STR_W-1:0];
            3'd5: desc.ocnt    <= rd_data[CNT_W-1:0];
            default: desc.ostride <= rd_data[STR_W-1:0];
          endcase
          if (idx == LAST_IDX) begin
            st   <= F_IDLE;
            done <= 1'b1;
          end else begin
            idx <= idx + 3'd1;
            off <= off + 3'd1;
            st  <= F_REQ;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk
  import dma2d_pkg::*;
#(
  parameter int unsigned ELEM_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  agen_desc_t        desc,
  input  logic              wrap,
  input  logic              xfer,
  output logic              active,
  output logic [ADDR_W-1:0] addr,
  output logic              row_end,
  output logic              buf_end,
  output logic              irq
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  agen_desc_t     d;
  logic [CNT_W:0] ileft;
  logic [CNT_W:0] oleft;
  logic           take;

  assign take    = active & xfer;
  assign row_end = take & (ileft == ONE);
  assign buf_end = row_end & (!d.two_d | (oleft == ONE));
  assign irq     = d.irq_row ? row_end : buf_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; addr <= '0; ileft <= '0; oleft <= '0; d <= '0;
    end else if (load) begin
      d      <= desc;
      addr   <= desc.start;
      ileft  <= count_load(desc.icnt);
      oleft  <= count_load(desc.ocnt);
      active <= 1'b1;
    end else if (take) begin
      if (buf_end) begin
        if (wrap) begin
          addr  <= d.start;
          ileft <= count_load(d.icnt);
          oleft <= count_load(d.ocnt);
        end else begin
          active <= 1'b0;
        end
      end else if (row_end) begin
        addr  <= step_addr(addr, d.ostride, ELEM_SHIFT);
        ileft <= count_load(d.icnt);
        oleft <= oleft - ONE;
      end else begin
        addr  <= step_addr(addr, d.istride, ELEM_SHIFT);
        ileft <= ileft - ONE;
      end
    end
  end
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
  import dma2d_pkg::*;
#(
  parameter int unsigned ELEM_SHIFT = 0,
  parameter int unsigned PAGE_LO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        reg_mode,
  input  logic [2:0]        reg_cfg,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_icnt,
  input  logic [STR_W-1:0]  reg_istride,
  input  logic [CNT_W-1:0]  reg_ocnt,
  input  logic [STR_W-1:0]  reg_ostride,
  input  logic [ADDR_W-1:0] reg_desc_ptr,
  input  logic [ADDR_W-1:0] reg_page,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_data,
  input  logic              xfer,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              row_done,
  output logic              buf_done,
  output logic              irq
);
  typedef enum logic [1:0] {T_IDLE, T_FETCH, T_RUN} tst_e;

  tst_e              st;
  agen_mode_e        mode_q;
  logic              chain_q;
  logic [ADDR_W-1:0] next_q;
  agen_desc_t        reg_desc, fetched, load_desc;
  logic              start_ok, from_list, fetch_go, fetch_done, walk_load;
  logic [ADDR_W-1:0] fetch_ptr;
  logic              listish_q;

  always_comb begin
    reg_desc         = '0;
    reg_desc.start   = reg_addr;
    reg_desc.two_d   = reg_cfg[0];
    reg_desc.irq_row = reg_cfg[1];
    reg_desc.icnt    = reg_icnt;
    reg_desc.istride = reg_istride;
    reg_desc.ocnt    = reg_ocnt;
    reg_desc.ostride = reg_ostride;
  end

  assign start_ok  = start && (st == T_IDLE);
  assign from_list = reg_mode[1];
  assign listish_q = (mode_q == MODE_LIST) || (mode_q == MODE_ARRAY);
  assign fetch_go  = (start_ok && from_list) ||
                     ((st == T_RUN) && buf_done && listish_q && chain_q);
  assign fetch_ptr = start_ok ? reg_desc_ptr : next_q;
  assign walk_load = (start_ok && !from_list) || fetch_done;
  assign load_desc = fetch_done ? fetched : reg_desc;

  dma2d_fetch #(.PAGE_LO_W(PAGE_LO_W)) i_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetch_go),
    .array_mode(start_ok ? (reg_mode == 2'd3) : (mode_q == MODE_ARRAY)),
    .ptr(fetch_ptr), .page(reg_page),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(fetch_done), .desc(fetched)
  );

  dma2d_walk #(.ELEM_SHIFT(ELEM_SHIFT)) i_walk (
    .clk(clk), .rst_n(rst_n), .load(walk_load), .desc(load_desc),
    .wrap(mode_q == MODE_CIRC), .xfer(xfer),
    .active(addr_valid), .addr(addr),
    .row_end(row_done), .buf_end(buf_done), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= T_IDLE; mode_q <= MODE_STOP; chain_q <= 1'b0; next_q <= '0;
    end else begin
      if (walk_load) begin
        chain_q <= load_desc.chain;
        next_q  <= load_desc.next;
      end
      case (st)
        T_IDLE: if (start) begin
          mode_q <= agen_mode_e'(reg_mode);
          st     <= from_list ? T_FETCH : T_RUN;
        end
        T_FETCH: if (fetch_done) st <= T_RUN;
        T_RUN: if (buf_done && (mode_q != MODE_CIRC))
          st <= (listish_q && chain_q) ? T_FETCH : T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma2d_agen_chk.sv
module dma2d_agen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xfer,
  input logic        addr_valid,
  input logic [31:0] addr,
  input logic        row_done,
  input logic        buf_done,
  input logic        irq,
  input logic        rd_req,
  input logic [1:0]  mode_now
);
  a_r4_row_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> (xfer && addr_valid));
  a_r4_buf_is_row_end: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> row_done);
  a_r5_irq_on_row: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> row_done);
  a_r7_stop_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_done && mode_now == 2'd0) |=> !addr_valid);
  a_r8_circ_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_done && mode_now == 2'd1) |=> addr_valid);
  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !xfer) |=> (addr_valid && $stable(addr)));
  a_r13_req_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r13_no_addr_while_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !addr_valid);
endmodule

bind dma2d_agen dma2d_agen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .xfer(xfer), .addr_valid(addr_valid), .addr(addr),
  .row_done(row_done), .buf_done(buf_done), .irq(irq), .rd_req(rd_req),
  .mode_now(mode_q)
);

// File: tb/test_dma2d_agen.sv
module test_dma2d_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  reg_mode = '0;
  logic [2:0]  reg_cfg = '0;
  logic [31:0] reg_addr = '0, reg_desc_ptr = '0, reg_page = '0;
  logic [15:0] reg_icnt = '0, reg_istride = '0, reg_ocnt = '0, reg_ostride = '0;
  logic        rd_req, rd_valid = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic        xfer = 1'b0;
  logic        addr_valid, row_done, buf_done, irq;
  logic [31:0] addr;
  logic [31:0] mem [0:63];
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma2d_agen i_dma2d_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_mode(reg_mode), .reg_cfg(reg_cfg),
    .reg_addr(reg_addr), .reg_icnt(reg_icnt), .reg_istride(reg_istride),
    .reg_ocnt(reg_ocnt), .reg_ostride(reg_ostride), .reg_desc_ptr(reg_desc_ptr),
    .reg_page(reg_page), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .xfer(xfer), .addr_valid(addr_valid), .addr(addr),
    .row_done(row_done), .buf_done(buf_done), .irq(irq)
  );

  // descriptor memory: one-cycle reply
  always @(posedge clk) begin
    rd_valid <= rd_req;
    rd_data  <= mem[rd_addr[5:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; xfer = 1'b0; start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic kick(input logic [1:0] m, input logic [2:0] cfg, input logic [31:0] a,
                      input int ic, input int is, input int oc, input int os);
    @(negedge clk);
    reg_mode = m; reg_cfg = cfg; reg_addr = a;
    reg_icnt = 16'(ic); reg_istride = 16'(is); reg_ocnt = 16'(oc); reg_ostride = 16'(os);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // one full buffer; expected address in closed form
  task automatic walk(input string req, input logic [31:0] base, input int ic, input int is,
                      input int oc, input int os, input bit twod, input bit irq_row);
    int icn, nrow;
    icn  = (ic == 0) ? 65536 : ic;
    nrow = twod ? ((oc == 0) ? 65536 : oc) : 1;
    for (int r = 0; r < nrow; r++) begin
      for (int c = 0; c < icn; c++) begin
        logic [31:0] exp;
        logic [2:0]  fl, efl;
        bit          rend, bend;
        if (!(r == 0 && c == 0)) @(negedge clk);
        xfer = 1'b0;
        while (!addr_valid) @(negedge clk);
        xfer = 1'b1;
        #1;
        exp  = base + 32'(r * ((icn - 1) * is + os)) + 32'(c * is);
        rend = (c == icn - 1);
        bend = rend && (r == nrow - 1);
        efl  = {rend, bend, irq_row ? rend : bend};
        fl   = {row_done, buf_done, irq};
        check(addr == exp, req, "address", addr, exp);
        check(fl == efl, req, "row/buf/irq flags (R4 R5)", 32'(fl), 32'(efl));
      end
    end
    @(negedge clk);
    xfer = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    // R9 linked chain at 8 -> 20
    mem[8]  = 32'd20; mem[9]  = 32'h0000_1000; mem[10] = 32'h4;
    mem[11] = 32'd4;  mem[12] = 32'd1;         mem[13] = 32'd9; mem[14] = 32'd9;
    mem[20] = 32'd0;  mem[21] = 32'h0000_2000; mem[22] = 32'h3;
    mem[23] = 32'd3;  mem[24] = 32'h0000_0002; mem[25] = 32'd2; mem[26] = 32'h0000_FFFB;
    // R10 array at 40, 46
    mem[40] = 32'h1234_0010; mem[41] = 32'h4; mem[42] = 32'd2; mem[43] = 32'd1;
    mem[44] = 32'd7;         mem[45] = 32'd7;
    mem[46] = 32'hFFFF_0200; mem[47] = 32'h1; mem[48] = 32'd2; mem[49] = 32'hFFFF;
    mem[50] = 32'd2;         mem[51] = 32'd5;

    repeat (2) @(negedge clk);
    check({addr_valid, rd_req, row_done, buf_done, irq} == 5'b0, "R1", "outputs in reset",
          32'({addr_valid, rd_req, row_done, buf_done, irq}), 0);
    rst_n = 1'b1;
    #1;
    check({addr_valid, rd_req, row_done, buf_done, irq} == 5'b0, "R1", "outputs after reset",
          32'({addr_valid, rd_req, row_done, buf_done, irq}), 0);

    // R11: strobes while idle
    xfer = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      check({addr_valid, row_done, buf_done, irq} == 4'b0, "R11", "idle strobe",
            32'({addr_valid, row_done, buf_done, irq}), 0);
    end
    xfer = 1'b0;

    // R3 R12 R7: 1-D, outer fields ignored
    kick(2'd0, 3'b000, 32'h100, 5, 2, 3, 100);
    walk("R12", 32'h100, 5, 2, 3, 100, 1'b0, 1'b0);
    #1;
    check(addr_valid == 1'b0, "R7", "idle after stop pass", 32'(addr_valid), 0);

    // R3: 2-D de-interleave, per-row irq (R5)
    kick(2'd0, 3'b011, 32'h200, 4, 3, 3, -8);
    walk("R3", 32'h200, 4, 3, 3, -8, 1'b1, 1'b1);
    #1;
    check(addr_valid == 1'b0, "R7", "idle after 2-D pass", 32'(addr_valid), 0);

    // R3: negative strides across zero
    kick(2'd0, 3'b001, 32'h10, 3, -4, 4, -2);
    walk("R3", 32'h10, 3, -4, 4, -2, 1'b1, 1'b0);

    // R11: strobe after stop did not disturb next start
    xfer = 1'b1; repeat (2) @(negedge clk); xfer = 1'b0;
    kick(2'd0, 3'b000, 32'h300, 2, 1, 0, 0);
    walk("R11", 32'h300, 2, 1, 0, 0, 1'b0, 1'b0);

    // R8: circular, three passes
    kick(2'd1, 3'b001, 32'h400, 3, 1, 2, 5);
    for (int p = 0; p < 3; p++) begin
      walk("R8", 32'h400, 3, 1, 2, 5, 1'b1, 1'b0);
      #1;
      check(addr_valid == 1'b1, "R8", "still valid after wrap", 32'(addr_valid), 1);
    end
    do_reset();

    // R9 chain; R2 start during fetch ignored; R13 valid low during fetch
    reg_desc_ptr = 32'd8;
    kick(2'd2, 3'b000, 32'h0, 1, 1, 1, 1);
    #1;
    check(addr_valid == 1'b0, "R13", "no address while fetching", 32'(addr_valid), 0);
    kick(2'd0, 3'b000, 32'hDEAD_0000, 2, 1, 0, 0);
    walk("R9", 32'h1000, 4, 1, 9, 9, 1'b0, 1'b0);
    #1;
    check(addr_valid == 1'b0, "R13", "fetch gap after chained buffer", 32'(addr_valid), 0);
    walk("R9", 32'h2000, 3, 2, 2, -5, 1'b1, 1'b1);
    #1;
    check(addr_valid == 1'b0, "R9", "chain ends idle", 32'(addr_valid), 0);
    repeat (3) @(negedge clk);
    check(addr_valid == 1'b0 && rd_req == 1'b0, "R9", "no further fetch",
          32'({addr_valid, rd_req}), 0);

    // R10 array with page
    reg_desc_ptr = 32'd40; reg_page = 32'hABCD_5555;
    kick(2'd3, 3'b000, 32'h0, 1, 1, 1, 1);
    walk("R10", 32'hABCD_0010, 2, 1, 7, 7, 1'b0, 1'b0);
    walk("R10", 32'hABCD_0200, 2, -1, 2, 5, 1'b1, 1'b0);
    #1;
    check(addr_valid == 1'b0, "R10", "array ends idle", 32'(addr_valid), 0);

    // R6: inner count 0 = 65536
    kick(2'd0, 3'b000, 32'h0001_0000, 0, 1, 0, 0);
    walk("R6", 32'h0001_0000, 0, 1, 0, 0, 1'b0, 1'b0);
    #1;
    check(addr_valid == 1'b0, "R6", "idle after 65536 elements", 32'(addr_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule